// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block raises a doorbell between the two sides of a shared memory. Each side (left and right) presents its own clocked access request: an address, a pair of chip enables and a read/write select. The two topmost addresses of the memory are set aside as mailboxes. The highest address belongs to the left side and the one below it belongs to the right side. When one side writes into the other side's mailbox, the owner's interrupt output goes low. The owner reads its own mailbox to fetch the message, and that read returns its interrupt output high.

The block observes the access requests and keeps one flag per side. The mailbox words themselves are held in the ordinary memory array outside this block. Arbitration between colliding accesses and byte-lane steering are also handled outside. An asynchronous master reset clears both flags.

Top module: `mbx_irq`

## Requirements
- R1: While the active-low master reset `mrstN` is low, both `lIntN` and `rIntN` are high. Reset takes effect without waiting for a clock edge.
- R2: A selected right-side write to the all-ones address drives `lIntN` low after that clock edge.
- R3: A selected left-side write to the all-ones-minus-one address drives `rIntN` low after that clock edge.
- R4: A selected left-side read (`lRdWrN` = 1) of the all-ones address returns `lIntN` high after that edge.
- R5: A selected right-side read (`rRdWrN` = 1) of the all-ones-minus-one address returns `rIntN` high after that edge.
- R6: A side's access counts only when its `Ce0N` is 0 and its `Ce1` is 1 at the clock edge. Any other chip-enable combination leaves both outputs unchanged.
- R7: If a set and a clear of the same flag fall on the same edge, the set wins and the interrupt output is low afterwards.
- R8: A side that writes to its own mailbox leaves both outputs unchanged.
- R9: Once set or cleared, a flag holds its value until one of its own set or clear events occurs. Accesses to other addresses, and reads of the other side's mailbox, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| mrstN | input | 1 | Asynchronous master reset, active low |
| lAddr | input | AW | Left-side address |
| lCe0N | input | 1 | Left-side chip enable, active low |
| lCe1 | input | 1 | Left-side chip enable, active high |
| lRdWrN | input | 1 | Left-side direction: 1 = read, 0 = write |
| rAddr | input | AW | Right-side address |
| rCe0N | input | 1 | Right-side chip enable, active low |
| rCe1 | input | 1 | Right-side chip enable, active high |
| rRdWrN | input | 1 | Right-side direction: 1 = read, 0 = write |
| lIntN | output | 1 | Left-side mailbox interrupt, active low |
| rIntN | output | 1 | Right-side mailbox interrupt, active low |

## Verification
Each flag drives its output through nothing but an inverter. A wrong flag value therefore shows on `lIntN` or `rIntN` in the cycle right after the edge that produced it, and it persists until the next set or clear event. A swapped mailbox decode, a chip-enable term that is ignored, or a clear that wins over a set each leaves an output at the wrong level one cycle after the offending access. The bench samples both outputs after every edge, so any such fault is exposed at the first vector that touches that condition.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  // Strobes passed from the access decoder to the flag registers
  typedef struct packed {
    logic setL;  // right side wrote the left mailbox
    logic clrL;  // left side read the left mailbox
    logic setR;  // left side wrote the right mailbox
    logic clrR;  // right side read the right mailbox
  } mbxStrobe_t;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_L    = 0;
  localparam int SIDE_R    = 1;

  // A side is selected when the low enable is 0 and the high enable is 1
  function automatic logic sideSelected(input logic ce0N, input logic ce1);
    return (~ce0N) & ce1;
  endfunction

endpackage

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic [NUM_SIDES-1:0][AW-1:0] addr,
  input  logic [NUM_SIDES-1:0]         ce0N,
  input  logic [NUM_SIDES-1:0]         ce1,
  input  logic [NUM_SIDES-1:0]         rdWrN,
  output mbxStrobe_t                   strobe
);

  localparam logic [AW-1:0] LEFT_BOX  = {AW{1'b1}};
  localparam logic [AW-1:0] RIGHT_BOX = LEFT_BOX - 1'b1;

  logic [NUM_SIDES-1:0] writesPeer;
  logic [NUM_SIDES-1:0] readsOwn;

  for (genvar p = 0; p < NUM_SIDES; p++) begin : g_side
    localparam logic [AW-1:0] OWN_BOX  = (p == SIDE_L) ? LEFT_BOX : RIGHT_BOX;
    localparam logic [AW-1:0] PEER_BOX = (p == SIDE_L) ? RIGHT_BOX : LEFT_BOX;

    logic active;
    assign active        = sideSelected(ce0N[p], ce1[p]);
    assign writesPeer[p] = active & ~rdWrN[p] & (addr[p] == PEER_BOX);
    assign readsOwn[p]   = active &  rdWrN[p] & (addr[p] == OWN_BOX);
  end

  always_comb begin
    strobe.setL = writesPeer[SIDE_R];
    strobe.clrL = readsOwn[SIDE_L];
    strobe.setR = writesPeer[SIDE_L];
    strobe.clrR = readsOwn[SIDE_R];
  end

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
  import mbx_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 mrstN,
  input  mbxStrobe_t           strobe,
  output logic [NUM_SIDES-1:0] intN
);

  logic [NUM_SIDES-1:0] setVec;
  logic [NUM_SIDES-1:0] clrVec;
  logic [NUM_SIDES-1:0] flag;

  assign setVec[SIDE_L] = strobe.setL;
  assign setVec[SIDE_R] = strobe.setR;
  assign clrVec[SIDE_L] = strobe.clrL;
  assign clrVec[SIDE_R] = strobe.clrR;

  for (genvar p = 0; p < NUM_SIDES; p++) begin : g_flag
    // Set has priority over clear so that a fresh message is never dropped
    always_ff @(posedge clk or negedge mrstN) begin
      if (!mrstN)         flag[p] <= 1'b0;
      else if (setVec[p]) flag[p] <= 1'b1;
      else if (clrVec[p]) flag[p] <= 1'b0;
    end
    assign intN[p] = ~flag[p];
  end

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_irq_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          mrstN,
  input  logic [AW-1:0] lAddr,
  input  logic          lCe0N,
  input  logic          lCe1,
  input  logic          lRdWrN,
  input  logic [AW-1:0] rAddr,
  input  logic          rCe0N,
  input  logic          rCe1,
  input  logic          rRdWrN,
  output logic          lIntN,
  output logic          rIntN
);

  mbxStrobe_t                   strobe;
  logic [NUM_SIDES-1:0]         intVec;
  logic [NUM_SIDES-1:0][AW-1:0] addrVec;

  assign addrVec[SIDE_L] = lAddr;
  assign addrVec[SIDE_R] = rAddr;

  mbx_irq_ctrl #(.AW(AW)) u_ctrl (
    .addr   (addrVec),
    .ce0N   ({rCe0N, lCe0N}),
    .ce1    ({rCe1, lCe1}),
    .rdWrN  ({rRdWrN, lRdWrN}),
    .strobe (strobe)
  );

  mbx_irq_flags u_flags (
    .clk    (clk),
    .mrstN  (mrstN),
    .strobe (strobe),
    .intN   (intVec)
  );

  assign lIntN = intVec[SIDE_L];
  assign rIntN = intVec[SIDE_R];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          mrstN,
  input logic [AW-1:0] lAddr,
  input logic          lCe0N,
  input logic          lCe1,
  input logic          lRdWrN,
  input logic [AW-1:0] rAddr,
  input logic          rCe0N,
  input logic          rCe1,
  input logic          rRdWrN,
  input logic          lIntN,
  input logic          rIntN
);

  localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

  logic lSel, rSel;
  logic evSetL, evClrL, evSetR, evClrR;

  assign lSel   = !lCe0N && lCe1;
  assign rSel   = !rCe0N && rCe1;
  assign evSetL = rSel && !rRdWrN && (rAddr == TOP_ADDR);
  assign evClrL = lSel &&  lRdWrN && (lAddr == TOP_ADDR);
  assign evSetR = lSel && !lRdWrN && (lAddr == NEXT_ADDR);
  assign evClrR = rSel &&  rRdWrN && (rAddr == NEXT_ADDR);

  // R1: outputs high whenever reset is held
  always @(posedge clk) begin
    if (!mrstN) begin
      p_reset_high_r1: assert (lIntN && rIntN);
    end
  end

  p_set_left_r2: assert property (@(posedge clk) disable iff (!mrstN)
    evSetL |=> !lIntN);

  p_set_right_r3: assert property (@(posedge clk) disable iff (!mrstN)
    evSetR |=> !rIntN);

  p_clr_left_r4: assert property (@(posedge clk) disable iff (!mrstN)
    (evClrL && !evSetL) |=> lIntN);

  p_clr_right_r5: assert property (@(posedge clk) disable iff (!mrstN)
    (evClrR && !evSetR) |=> rIntN);

  // R6, R8, R9: without a qualifying event a flag keeps its level
  p_hold_left_r9: assert property (@(posedge clk) disable iff (!mrstN)
    (!evSetL && !evClrL) |=> $stable(lIntN));

  p_hold_right_r9: assert property (@(posedge clk) disable iff (!mrstN)
    (!evSetR && !evClrR) |=> $stable(rIntN));

  // R7: a set and a clear together leave the output low
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!mrstN)
    (evSetL && evClrL) |=> !lIntN);

endmodule

bind mbx_irq mbx_irq_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .mrstN  (mrstN),
  .lAddr  (lAddr),
  .lCe0N  (lCe0N),
  .lCe1   (lCe1),
  .lRdWrN (lRdWrN),
  .rAddr  (rAddr),
  .rCe0N  (rCe0N),
  .rCe1   (rCe1),
  .rRdWrN (rRdWrN),
  .lIntN  (lIntN),
  .rIntN  (rIntN)
);

// File: tb/tb_mbx_irq.sv
`timescale 1ns/1ps
module tb_mbx_irq;

  localparam int AW = 18;

  // operation codes and address selectors used in the vector table
  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;
  localparam logic [1:0] A_LBOX = 2'd0, A_RBOX = 2'd1, A_MID = 2'd2, A_LOW = 2'd3;

  function automatic logic [15:0] mk(input logic [3:0] req, input logic [1:0] lop,
      input logic [1:0] la, input logic [1:0] rop, input logic [1:0] ra,
      input logic el, input logic er);
    return {req, lop, la, rop, ra, 2'b00, el, er};
  endfunction

  localparam int NVEC = 18;
  localparam logic [15:0] VEC [NVEC] = '{
    mk(4'd9, OP_IDLE, A_LBOX, OP_IDLE, A_LBOX, 1'b1, 1'b1), // idle, R9
    mk(4'd2, OP_IDLE, A_LBOX, OP_WR,   A_LBOX, 1'b0, 1'b1), // R2
    mk(4'd9, OP_IDLE, A_LBOX, OP_IDLE, A_LBOX, 1'b0, 1'b1), // hold, R9
    mk(4'd9, OP_RD,   A_RBOX, OP_IDLE, A_LBOX, 1'b0, 1'b1), // peer box read, R9
    mk(4'd9, OP_RD,   A_MID,  OP_IDLE, A_LBOX, 1'b0, 1'b1), // other addr, R9
    mk(4'd4, OP_RD,   A_LBOX, OP_IDLE, A_LBOX, 1'b1, 1'b1), // R4
    mk(4'd3, OP_WR,   A_RBOX, OP_IDLE, A_LBOX, 1'b1, 1'b0), // R3
    mk(4'd8, OP_IDLE, A_LBOX, OP_WR,   A_RBOX, 1'b1, 1'b0), // own write, R8
    mk(4'd9, OP_IDLE, A_LBOX, OP_RD,   A_LBOX, 1'b1, 1'b0), // R9
    mk(4'd5, OP_IDLE, A_LBOX, OP_RD,   A_RBOX, 1'b1, 1'b1), // R5
    mk(4'd8, OP_WR,   A_LBOX, OP_IDLE, A_LBOX, 1'b1, 1'b1), // own write, R8
    mk(4'd7, OP_RD,   A_LBOX, OP_WR,   A_LBOX, 1'b0, 1'b1), // R7 left
    mk(4'd4, OP_RD,   A_LBOX, OP_IDLE, A_LBOX, 1'b1, 1'b1), // R4
    mk(4'd7, OP_WR,   A_RBOX, OP_RD,   A_RBOX, 1'b1, 1'b0), // R7 right
    mk(4'd5, OP_IDLE, A_LBOX, OP_RD,   A_RBOX, 1'b1, 1'b1), // R5
    mk(4'd2, OP_WR,   A_RBOX, OP_WR,   A_LBOX, 1'b0, 1'b0), // R2 and R3 together
    mk(4'd9, OP_WR,   A_LOW,  OP_WR,   A_MID,  1'b0, 1'b0), // R9
    mk(4'd4, OP_RD,   A_LBOX, OP_RD,   A_RBOX, 1'b1, 1'b1)  // R4 and R5 together
  };

  logic          clk = 1'b0;
  logic          mrstN;
  logic [AW-1:0] lAddr, rAddr;
  logic          lCe0N, lCe1, lRdWrN, rCe0N, rCe1, rRdWrN;
  logic          lIntN, rIntN;

  int testsRun  = 0;
  int testsFail = 0;

  always #2.5 clk = ~clk;

  mbx_irq #(.AW(AW)) dut (
    .clk(clk), .mrstN(mrstN),
    .lAddr(lAddr), .lCe0N(lCe0N), .lCe1(lCe1), .lRdWrN(lRdWrN),
    .rAddr(rAddr), .rCe0N(rCe0N), .rCe1(rCe1), .rRdWrN(rRdWrN),
    .lIntN(lIntN), .rIntN(rIntN)
  );

  function automatic logic [AW-1:0] addrOf(input logic [1:0] sel);
    case (sel)
      A_LBOX:  return {AW{1'b1}};
      A_RBOX:  return {AW{1'b1}} - 1'b1;
      A_MID:   return AW'(18'h01234);
      default: return {AW{1'b1}} - 2'd2;
    endcase
  endfunction

  task automatic driveSides(input logic [1:0] lop, input logic [1:0] la,
                            input logic [1:0] rop, input logic [1:0] ra);
    lAddr  = addrOf(la);  rAddr  = addrOf(ra);
    lCe0N  = (lop == OP_IDLE); lCe1 = (lop != OP_IDLE);
    rCe0N  = (rop == OP_IDLE); rCe1 = (rop != OP_IDLE);
    lRdWrN = (lop != OP_WR);   rRdWrN = (rop != OP_WR);
  endtask

  task automatic check(input string req, input logic expL, input logic expR);
    testsRun++;
    if (lIntN !== expL || rIntN !== expR) begin
      testsFail++;
      $display("FAIL %s: lIntN/rIntN got %b%b expected %b%b", req, lIntN, rIntN, expL, expR);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    mrstN = 1'b0;
    driveSides(OP_IDLE, A_LBOX, OP_IDLE, A_LBOX);
    repeat (3) @(negedge clk);
    check("R1", 1'b1, 1'b1);
    mrstN = 1'b1;

    // table walk: drive on falling edge, sample on the next falling edge
    for (int i = 0; i < NVEC; i++) begin
      driveSides(VEC[i][11:10], VEC[i][9:8], VEC[i][7:6], VEC[i][5:4]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][15:12], i), VEC[i][1], VEC[i][0]);
    end

    // R6: right write to left box with low enable deasserted
    driveSides(OP_IDLE, A_LBOX, OP_WR, A_LBOX);
    rCe0N = 1'b1; rCe1 = 1'b1;
    @(negedge clk); check("R6 ce0N high", 1'b1, 1'b1);
    // R6: same with high enable deasserted
    rCe0N = 1'b0; rCe1 = 1'b0;
    @(negedge clk); check("R6 ce1 low", 1'b1, 1'b1);
    // R6: left write to right box with both enables off
    driveSides(OP_WR, A_RBOX, OP_IDLE, A_LBOX);
    lCe0N = 1'b1; lCe1 = 1'b0;
    @(negedge clk); check("R6 both off", 1'b1, 1'b1);

    // set both, then try deselected clearing reads
    driveSides(OP_WR, A_RBOX, OP_WR, A_LBOX);
    @(negedge clk); check("R2 R3 set", 1'b0, 1'b0);
    driveSides(OP_RD, A_LBOX, OP_RD, A_RBOX);
    lCe1 = 1'b0; rCe0N = 1'b1;
    @(negedge clk); check("R6 clear ignored", 1'b0, 1'b0);

    // R1: asynchronous reset between edges
    driveSides(OP_IDLE, A_LBOX, OP_IDLE, A_LBOX);
    #1 mrstN = 1'b0;
    #0.5 check("R1 async", 1'b1, 1'b1);
    @(negedge clk); check("R1 held", 1'b1, 1'b1);
    mrstN = 1'b1;
    @(negedge clk); check("R9 after reset", 1'b1, 1'b1);

    finishRun();
  end

endmodule